// File: doc/BRIEF.md
# Flash Prefetch and Program Cache

This block sits between a 32-bit processor and a slow flash array that delivers one 128-bit line per read. It has two modes, chosen by `cache_en_i`. With the cache off, each processor read starts its own array read. The data goes straight through, and the access takes `wait_st_i + 1` cycles. With the cache on, instruction fetches are looked up in an eight-line direct-mapped program cache. After each instruction fetch, a look-ahead prefetcher loads the next sequential line into that cache. Data reads use a separate single-line buffer.

The array side is a plain read port. `fl_rd_o` stays high for the whole access, and `fl_line_o` holds the line address steady. The array must present the line on `fl_rdata_i` by the last cycle of the access, so it is read with a fixed latency. Only one array access is outstanding at any time. Each processor port uses a request/ready pair. The requester holds its request and address until ready is high, and the transfer completes at the clock edge that ends that cycle.

Top module: `flash_fetch_unit`

## Requirements
- R1: With `cache_en_i` low, every instruction or data read starts its own array access, even when the same address is read again. It returns the addressed word in the last cycle of that access.
- R2: An array access lasts `wait_st_i + 1` cycles. With `wait_st_i` = 0, a read with the cache off is ready in the same cycle it is requested.
- R3: With the cache on, an instruction fetch that hits is ready in the cycle of the request, with no array access. Address bits [3:2] select the returned word: 0 is the lowest 32 bits of the line.
- R4: An instruction miss costs one array access of `wait_st_i + 1` cycles. Ready is raised in its last cycle. The line is stored at index bits [6:4], with bits [31:7] as its tag.
- R5: When an instruction fetch completes at line L, the next idle cycle starts a prefetch of line L+1 into the program cache, unless that line is already present. A later fetch from L+1 then hits.
- R6: Prefetching follows the last fetched address. After a jump, the next prefetch targets the line after the jump target.
- R7: Two lines with the same index and different tags evict each other.
- R8: Data reads use only the one-line buffer. A buffer hit is ready in the request cycle, and a miss refills the whole line with one access. Data reads never fill the program cache, and instruction fetches never fill the buffer.
- R9: When several sources need the array in the same idle cycle, they are served in this order: instruction demand, then data demand, then prefetch. The line address stays stable while an access is in progress.
- R10: A demand for a line that a prefetch is already fetching waits for that prefetch and does not issue a second access.
- R11: Reset, and every change of `cache_en_i`, invalidates all program-cache lines and the data buffer.
- R12: A ready output stays low until its requested word is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_en_i | input | 1 | 1: cache mode, 0: every read goes to the array |
| wait_st_i | input | 4 | Extra cycles per array access |
| if_req_i | input | 1 | Instruction fetch request |
| if_addr_i | input | 32 | Instruction byte address |
| if_rdata_o | output | 32 | Instruction word |
| if_rdy_o | output | 1 | Instruction word valid, transfer completes |
| dr_req_i | input | 1 | Data read request |
| dr_addr_i | input | 32 | Data byte address |
| dr_rdata_o | output | 32 | Data word |
| dr_rdy_o | output | 1 | Data word valid, transfer completes |
| fl_rd_o | output | 1 | Array access in progress |
| fl_line_o | output | 28 | Line address being read |
| fl_rdata_i | input | 128 | Line returned by the array |

## Verification
Every read is timed in cycles from the first cycle its request is presented:
- A hit of either kind is due in that same cycle.
- A miss, or any read with the cache off, is due `wait_st_i` cycles later.
- A fetch that lands on a line being prefetched is due the cycle after the prefetch ends.
- A data read that loses arbitration to an instruction is due `2*wait_st_i + 1` cycles after the request.

The bench counts these cycles directly: it samples ready at each falling edge while the request is held, and compares the count with the due value. The bench also records the line address at the start of every array access. From this record it checks prefetch targets, arbitration order, and that no second access is made.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    ACC_INS = 2'd0,
    ACC_DAT = 2'd1,
    ACC_PF  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/flc_array_seq.sv
module flc_array_seq
  import flc_pkg::*;
#(
  parameter int LA_W = 28,
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WS_W-1:0] wait_st_i,
  input  logic            start_i,
  input  logic [LA_W-1:0] start_line_i,
  input  acc_kind_e       start_kind_i,
  input  logic            start_cen_i,
  output logic            act_o,
  output logic            busy_o,
  output logic [LA_W-1:0] act_line_o,
  output acc_kind_e       act_kind_o,
  output logic            act_cen_o,
  output logic            done_o
);
  logic            busy_q;
  logic [WS_W-1:0] cnt_q;
  logic [LA_W-1:0] line_q;
  acc_kind_e       kind_q;
  logic            cen_q;
  logic [WS_W-1:0] elapsed;

  assign act_o      = busy_q | start_i;
  assign busy_o     = busy_q;
  assign elapsed    = busy_q ? cnt_q : '0;
  assign done_o     = act_o && (elapsed == wait_st_i);
  assign act_line_o = busy_q ? line_q : start_line_i;
  assign act_kind_o = busy_q ? kind_q : start_kind_i;
  assign act_cen_o  = busy_q ? cen_q  : start_cen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      line_q <= '0;
      kind_q <= ACC_INS;
      cen_q  <= 1'b0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end else if (start_i && !done_o) begin
      busy_q <= 1'b1;
      cnt_q  <= {{(WS_W-1){1'b0}}, 1'b1};
      line_q <= start_line_i;
      kind_q <= start_kind_i;
      cen_q  <= start_cen_i;
    end
  end

  AST_LINE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o && !done_o |=> act_o && $stable(act_line_o)); // R9
endmodule

// File: rtl/flc_prog_cache.sv
module flc_prog_cache #(
  parameter int LA_W   = 28,
  parameter int LINE_W = 128,
  parameter int NLINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [LA_W-1:0]   rd_line_i,
  output logic              rd_hit_o,
  output logic [LINE_W-1:0] rd_data_o,
  input  logic [LA_W-1:0]   pr_line_i,
  output logic              pr_hit_o,
  input  logic              wr_en_i,
  input  logic [LA_W-1:0]   wr_line_i,
  input  logic [LINE_W-1:0] wr_data_i
);
  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = LA_W - IDX_W;

  logic [NLINES-1:0] valid_q;
  logic [TAG_W-1:0]  tag_q  [NLINES];
  logic [LINE_W-1:0] data_q [NLINES];

  logic [IDX_W-1:0] rd_idx, pr_idx, wr_idx;
  assign rd_idx = rd_line_i[IDX_W-1:0];
  assign pr_idx = pr_line_i[IDX_W-1:0];
  assign wr_idx = wr_line_i[IDX_W-1:0];

  assign rd_hit_o  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_line_i[LA_W-1:IDX_W]);
  assign pr_hit_o  = valid_q[pr_idx] && (tag_q[pr_idx] == pr_line_i[LA_W-1:IDX_W]);
  assign rd_data_o = data_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NLINES; i++) tag_q[i] <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_line_i[LA_W-1:IDX_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_idx] <= wr_data_i;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R11
endmodule

// File: rtl/flc_data_buf.sv
module flc_data_buf #(
  parameter int LA_W   = 28,
  parameter int LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [LA_W-1:0]   rd_line_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] data_o,
  input  logic              wr_en_i,
  input  logic [LA_W-1:0]   wr_line_i,
  input  logic [LINE_W-1:0] wr_data_i
);
  logic              valid_q;
  logic [LA_W-1:0]   tag_q;
  logic [LINE_W-1:0] data_q;

  assign hit_o  = valid_q && (tag_q == rd_line_i);
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (wr_en_i) begin
      valid_q <= 1'b1;
      tag_q   <= wr_line_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q <= wr_data_i;
  end

  AST_DBUF_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !flush_i |=> valid_q && (tag_q == $past(wr_line_i))); // R8
endmodule

// File: rtl/flash_fetch_unit.sv
module flash_fetch_unit
  import flc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LINE_W = 128,
  parameter int NLINES = 8,
  parameter int WS_W   = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cache_en_i,
  input  logic [WS_W-1:0]                      wait_st_i,
  input  logic                                 if_req_i,
  input  logic [ADDR_W-1:0]                    if_addr_i,
  output logic [WORD_W-1:0]                    if_rdata_o,
  output logic                                 if_rdy_o,
  input  logic                                 dr_req_i,
  input  logic [ADDR_W-1:0]                    dr_addr_i,
  output logic [WORD_W-1:0]                    dr_rdata_o,
  output logic                                 dr_rdy_o,
  output logic                                 fl_rd_o,
  output logic [ADDR_W-$clog2(LINE_W/8)-1:0]   fl_line_o,
  input  logic [LINE_W-1:0]                    fl_rdata_i
);
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int WSEL_W = $clog2(LINE_W / WORD_W);
  localparam int BYTE_W = OFF_W - WSEL_W;
  localparam int LA_W   = ADDR_W - OFF_W;

  logic cen_q, flush;
  assign flush = cache_en_i ^ cen_q;

  logic [LA_W-1:0]   if_line, dr_line;
  logic [WSEL_W-1:0] if_wsel, dr_wsel;
  assign if_line = if_addr_i[ADDR_W-1:OFF_W];
  assign dr_line = dr_addr_i[ADDR_W-1:OFF_W];
  assign if_wsel = if_addr_i[OFF_W-1 -: WSEL_W];
  assign dr_wsel = dr_addr_i[OFF_W-1 -: WSEL_W];

  logic unused_byte_bits;
  assign unused_byte_bits = ^{if_addr_i[BYTE_W-1:0], dr_addr_i[BYTE_W-1:0]};

  logic              pf_pend_q;
  logic [LA_W-1:0]   pf_line_q;
  logic              pc_hit, pc_pr_hit, db_hit, pc_wr, db_wr;
  logic [LINE_W-1:0] pc_data, db_data;

  logic              act, busy, done, act_cen;
  logic [LA_W-1:0]   act_line, sel_line;
  acc_kind_e         act_kind, sel_kind;

  logic i_hit, d_hit, i_need, d_need, pf_need, start, fill_ok, i_from_fl, d_from_fl;

  assign i_hit   = cache_en_i && pc_hit;
  assign d_hit   = cache_en_i && db_hit;
  assign i_need  = if_req_i && !i_hit;
  assign d_need  = dr_req_i && !d_hit;
  assign pf_need = cache_en_i && pf_pend_q && !pc_pr_hit;
  assign start   = !busy && (i_need || d_need || pf_need);

  // fixed priority: instruction demand, data demand, prefetch
  always_comb begin
    sel_kind = ACC_PF;
    sel_line = pf_line_q;
    if (i_need) begin
      sel_kind = ACC_INS;
      sel_line = if_line;
    end else if (d_need) begin
      sel_kind = ACC_DAT;
      sel_line = dr_line;
    end
  end

  flc_array_seq #(.LA_W(LA_W), .WS_W(WS_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wait_st_i    (wait_st_i),
    .start_i      (start),
    .start_line_i (sel_line),
    .start_kind_i (sel_kind),
    .start_cen_i  (cache_en_i),
    .act_o        (act),
    .busy_o       (busy),
    .act_line_o   (act_line),
    .act_kind_o   (act_kind),
    .act_cen_o    (act_cen),
    .done_o       (done)
  );

  // no fill from an access issued before a mode change
  assign fill_ok   = done && act_cen && cache_en_i && !flush;
  assign pc_wr     = fill_ok && (act_kind != ACC_DAT);
  assign db_wr     = fill_ok && (act_kind == ACC_DAT);
  assign i_from_fl = done && (act_kind == ACC_INS);
  assign d_from_fl = done && (act_kind == ACC_DAT);

  flc_prog_cache #(.LA_W(LA_W), .LINE_W(LINE_W), .NLINES(NLINES)) u_pcache (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .rd_line_i (if_line),
    .rd_hit_o  (pc_hit),
    .rd_data_o (pc_data),
    .pr_line_i (pf_line_q),
    .pr_hit_o  (pc_pr_hit),
    .wr_en_i   (pc_wr),
    .wr_line_i (act_line),
    .wr_data_i (fl_rdata_i)
  );

  flc_data_buf #(.LA_W(LA_W), .LINE_W(LINE_W)) u_dbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .rd_line_i (dr_line),
    .hit_o     (db_hit),
    .data_o    (db_data),
    .wr_en_i   (db_wr),
    .wr_line_i (act_line),
    .wr_data_i (fl_rdata_i)
  );

  logic [LINE_W-1:0] if_src, dr_src;
  assign if_src     = i_from_fl ? fl_rdata_i : pc_data;
  assign dr_src     = d_from_fl ? fl_rdata_i : db_data;
  assign if_rdata_o = if_src[if_wsel*WORD_W +: WORD_W];
  assign dr_rdata_o = dr_src[dr_wsel*WORD_W +: WORD_W];
  assign if_rdy_o   = if_req_i && (i_hit || i_from_fl);
  assign dr_rdy_o   = dr_req_i && (d_hit || d_from_fl);
  assign fl_rd_o    = act;
  assign fl_line_o  = act_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q     <= 1'b0;
      pf_pend_q <= 1'b0;
      pf_line_q <= '0;
    end else begin
      cen_q <= cache_en_i;
      if (flush || !cache_en_i) begin
        pf_pend_q <= 1'b0;
      end else if (if_rdy_o) begin
        pf_pend_q <= 1'b1;
        pf_line_q <= if_line + 1'b1;
      end else if ((start && sel_kind == ACC_PF) || (pf_pend_q && pc_pr_hit)) begin
        pf_pend_q <= 1'b0;
      end
    end
  end

  AST_ZERO_WS_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cache_en_i && (wait_st_i == '0) && if_req_i && !busy |-> if_rdy_o); // R2
  AST_BYP_SINGLE_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cache_en_i |-> !(if_rdy_o && dr_rdy_o)); // R9
  AST_BYP_NEEDS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cache_en_i && (if_rdy_o || dr_rdy_o) |-> fl_rd_o); // R1
endmodule

// File: tb/sim_flash_fetch_unit.sv
module sim_flash_fetch_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cache_en = 1'b0;
  logic [3:0]   wait_st = 4'd0;
  logic         if_req = 1'b0, dr_req = 1'b0;
  logic [31:0]  if_addr = '0, dr_addr = '0;
  logic [31:0]  if_rdata, dr_rdata;
  logic         if_rdy, dr_rdy, fl_rd;
  logic [27:0]  fl_line;
  logic [127:0] fl_rdata;

  int n_chk = 0, n_fail = 0;
  int run = 0, n_st = 0;
  logic [27:0] st_line [0:255];

  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input logic [27:0] l, input logic [1:0] k);
    return {l, k, 2'b10};
  endfunction

  assign fl_rdata = {mk(fl_line, 2'd3), mk(fl_line, 2'd2), mk(fl_line, 2'd1), mk(fl_line, 2'd0)};

  flash_fetch_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cache_en_i(cache_en), .wait_st_i(wait_st),
    .if_req_i(if_req), .if_addr_i(if_addr), .if_rdata_o(if_rdata), .if_rdy_o(if_rdy),
    .dr_req_i(dr_req), .dr_addr_i(dr_addr), .dr_rdata_o(dr_rdata), .dr_rdy_o(dr_rdy),
    .fl_rd_o(fl_rd), .fl_line_o(fl_line), .fl_rdata_i(fl_rdata)
  );

  // access-start recorder: each access is wait_st+1 cycles long
  always @(negedge clk) begin
    if (!rst_n) run = 0;
    else if (fl_rd) begin
      if (run == 0) begin
        st_line[n_st % 256] = fl_line;
        n_st++;
      end
      run = (run >= int'(wait_st)) ? 0 : run + 1;
    end else run = 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ifetch(input logic [31:0] a, output int lat, output logic [31:0] d);
    if_addr = a; if_req = 1'b1; lat = 0;
    @(negedge clk);
    while (!if_rdy && lat < 200) begin lat++; @(negedge clk); end
    d = if_rdata;
    @(posedge clk); #1 if_req = 1'b0;
  endtask

  task automatic dread(input logic [31:0] a, output int lat, output logic [31:0] d);
    dr_addr = a; dr_req = 1'b1; lat = 0;
    @(negedge clk);
    while (!dr_rdy && lat < 200) begin lat++; @(negedge clk); end
    d = dr_rdata;
    @(posedge clk); #1 dr_req = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 reset if_rdy", 32'(if_rdy), 0);
    check("R11 reset dr_rdy", 32'(dr_rdy), 0);
    check("R11 reset fl_rd", 32'(fl_rd), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_bypass();
    int lat; logic [31:0] d; int b;
    cache_en = 1'b0; wait_st = 4'd3; idle(2);
    b = n_st;
    for (int i = 0; i < 2; i++) begin
      ifetch(32'h0000_0100, lat, d);
      check("R1 bypass fetch data", d, mk(28'h10, 2'd0));
      check("R12 bypass fetch latency", lat, 3);
    end
    dread(32'h0000_0104, lat, d);
    check("R1 bypass data word", d, mk(28'h10, 2'd1));
    check("R2 bypass data latency", lat, 3);
    check("R1 one access per read", n_st - b, 3);
    wait_st = 4'd0; idle(1);
    ifetch(32'h0000_0208, lat, d);
    check("R2 zero wait latency", lat, 0);
    check("R2 zero wait data", d, mk(28'h20, 2'd2));
  endtask

  task automatic t_dual();
    int c = 0, il = -1, dl = -1; logic [31:0] id = '0, dd = '0;
    cache_en = 1'b0; wait_st = 4'd2; idle(2);
    if_addr = 32'h0000_0400; dr_addr = 32'h0000_0504;
    if_req = 1'b1; dr_req = 1'b1;
    while ((il < 0 || dl < 0) && c < 100) begin
      @(negedge clk);
      if (if_req && if_rdy) begin il = c; id = if_rdata; end
      if (dr_req && dr_rdy) begin dl = c; dd = dr_rdata; end
      @(posedge clk); #1;
      if (il >= 0) if_req = 1'b0;
      if (dl >= 0) dr_req = 1'b0;
      c++;
    end
    check("R9 instruction wins latency", il, 2);
    check("R9 data waits latency", dl, 5);
    check("R9 instruction data", id, mk(28'h40, 2'd0));
    check("R9 data word", dd, mk(28'h50, 2'd1));
  endtask

  task automatic t_cache_basic();
    int lat; logic [31:0] d; int b;
    cache_en = 1'b1; wait_st = 4'd2; idle(2);
    b = n_st;
    ifetch(32'h0000_1004, lat, d);
    check("R4 miss latency", lat, 2);
    check("R4 miss data", d, mk(28'h100, 2'd1));
    idle(6);
    check("R5 prefetch issued", n_st - b, 2);
    check("R5 prefetch line", st_line[(b + 1) % 256], 28'h101);
    ifetch(32'h0000_1008, lat, d);
    check("R3 hit latency", lat, 0);
    check("R3 word select", d, mk(28'h100, 2'd2));
    ifetch(32'h0000_101C, lat, d);
    check("R5 prefetched hit latency", lat, 0);
    check("R5 prefetched data", d, mk(28'h101, 2'd3));
    idle(6);
  endtask

  task automatic t_branch();
    int lat; logic [31:0] d; int b;
    b = n_st;
    ifetch(32'h0000_2000, lat, d);
    check("R6 jump miss latency", lat, 2);
    idle(6);
    check("R6 prefetch after jump", st_line[(b + 1) % 256], 28'h201);
    ifetch(32'h0000_2014, lat, d);
    check("R6 hit after jump", lat, 0);
    check("R6 data after jump", d, mk(28'h201, 2'd1));
    idle(6);
  endtask

  task automatic t_conflict();
    int lat; logic [31:0] d;
    ifetch(32'h0000_3004, lat, d);
    check("R7 conflicting line miss", lat, 2);
    idle(6);
    ifetch(32'h0000_2008, lat, d);
    check("R7 evicted line misses", lat, 2);
    check("R7 evicted line data", d, mk(28'h200, 2'd2));
    idle(6);
  endtask

  task automatic t_data();
    int lat; logic [31:0] d; int b;
    dread(32'h0000_3008, lat, d);
    check("R8 buffer empty miss", lat, 2);
    check("R8 miss data", d, mk(28'h300, 2'd2));
    b = n_st;
    dread(32'h0000_300C, lat, d);
    check("R8 buffer hit latency", lat, 0);
    check("R8 buffer hit data", d, mk(28'h300, 2'd3));
    check("R8 hit makes no access", n_st - b, 0);
    dread(32'h0000_5000, lat, d);
    check("R8 buffer refill", lat, 2);
    idle(2);
    ifetch(32'h0000_5004, lat, d);
    check("R8 data not in program cache", lat, 2);
    idle(6);
  endtask

  task automatic t_priority();
    int lat; logic [31:0] d; int b;
    b = n_st;
    ifetch(32'h0000_6004, lat, d);
    ifetch(32'h0000_7000, lat, d);
    check("R9 demand before prefetch", st_line[(b + 1) % 256], 28'h700);
    check("R9 demand latency", lat, 2);
    idle(6);
  endtask

  task automatic t_wait_pf();
    int lat; logic [31:0] d; int b;
    b = n_st;
    ifetch(32'h0000_8004, lat, d);
    idle(1);
    ifetch(32'h0000_8010, lat, d);
    check("R10 wait on prefetch latency", lat, 2);
    check("R10 data", d, mk(28'h801, 2'd0));
    idle(6);
    check("R10 no duplicate access", st_line[(b + 2) % 256], 28'h802);
    check("R10 access count", n_st - b, 3);
  endtask

  task automatic t_toggle();
    int lat; logic [31:0] d;
    ifetch(32'h0000_9004, lat, d);
    dread(32'h0000_9008, lat, d);
    idle(6);
    ifetch(32'h0000_9004, lat, d);
    check("R11 cached before toggle", lat, 0);
    dread(32'h0000_9008, lat, d);
    check("R11 buffered before toggle", lat, 0);
    cache_en = 1'b0; idle(1);
    cache_en = 1'b1; idle(1);
    ifetch(32'h0000_9004, lat, d);
    check("R11 program cache invalidated", lat, 2);
    dread(32'h0000_9008, lat, d);
    check("R11 data buffer invalidated", lat, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_dual();
    t_cache_basic();
    t_branch();
    t_conflict();
    t_data();
    t_priority();
    t_wait_pf();
    t_toggle();
    idle(2);
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule